// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and rules on each incoming frame by its destination address. A frame addressed exactly to the station is kept. The all-ones broadcast address is always kept. Any other group address is kept only when its hash bit is set in a 256-bit table that software loads, and only while hash filtering is switched on. A promiscuous switch keeps everything.

The hash is the reflected CRC-32 of the six address bytes. The initial value is all ones, the polynomial is 0xEDB88320, each byte is fed least significant bit first, and no final complement is applied. The CRC is worked out serially at one byte per clock. The top eight bits of the result pick one bit of the table: the upper four select one of sixteen 16-bit words and the lower four select the bit inside that word.

Software programs the block through a simple write port. The frame parser presents the destination address with a one-cycle strobe and receives a one-cycle decision pulse a fixed number of cycles later.

Top module: `rx_addr_filter`

## Requirements
- R1: After synchronous reset, `dec_valid` and `dec_accept` are 0 and every register is 0. This means hashing and promiscuous mode are off, the table is empty and the station address is 00:00:00:00:00:00.
- R2: A strobe accepted at clock edge N gives `dec_valid` high for exactly the one cycle that follows edge N+7. `dec_valid` is low at all other times.
- R3: A strobe that arrives while an address is still being evaluated (edges N+1 to N+7) is ignored. It produces no extra decision and does not change the pending result.
- R4: Address `da[47:40]` is byte 0, the first byte on the wire. The station address is written as three 16-bit words: offset 16 holds bytes 4 and 5, offset 17 holds bytes 2 and 3, offset 18 holds bytes 0 and 1, with the lower-numbered byte in the upper half of each word. A unicast address equal to the station address is accepted.
- R5: A unicast address (bit `da[40]` clear) that differs from the station address in any bit is rejected unless promiscuous mode is on.
- R6: Table word k is written at offset k (0 to 15). For a group address other than broadcast, with hashing on, the frame is accepted exactly when table bit `word[idx[7:4]][idx[3:0]]` is set, where `idx` is bits [31:24] of the reflected CRC-32 of bytes 0 to 5.
- R7: With hashing off (bit 0 of the control word at offset 19 clear), every group address other than broadcast is rejected, whatever the table holds.
- R8: Promiscuous mode (bit 1 of the control word at offset 19) accepts every address and takes precedence over the hash enable bit.
- R9: The broadcast address FF:FF:FF:FF:FF:FF is always accepted, whatever the control word says.
- R10: When all sixteen table words hold 0xFFFF and hashing is on, every group address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register offset: 0-15 table words, 16-18 station words, 19 control |
| cfg_wdata | input | 16 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Accept (1) or reject (0), meaningful while dec_valid is high |

## Verification
The bench loads a single table bit for a known group address and then moves that bit to its neighbour. A design that reverses the CRC, takes the wrong CRC byte, or swaps the word and bit fields of the index would accept in the wrong case. Station words are tested with addresses that differ only in the last byte, which catches a design that swaps the order of the words or of the bytes inside them. Strobes held high through the whole evaluation window must yield one pulse carrying the first address's result; a design that restarts on a busy strobe would report late or report the wrong address. Broadcast with everything off and promiscuous with hashing off check the precedence order among the accept paths.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

    localparam int          DA_W       = 48;
    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_FINAL
    } eng_state_t;

    // control word at the control offset: bit0 hash enable, bit1 promiscuous
    typedef struct packed {
        logic promisc;
        logic hash_en;
    } ctrl_t;

    // handoff from the CRC engine to the decision stage
    typedef struct packed {
        logic             valid;
        logic [CRC_W-1:0] crc;
        logic [DA_W-1:0]  da;
    } hash_req_t;

    // one byte of the reflected CRC, least significant bit first
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                        input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-8){1'b0}}, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/addr_filt_regs.sv
module addr_filt_regs
    import addr_filt_pkg::*;
#(
    parameter int HASH_WORDS = 16,
    parameter int WORD_W     = 16,
    parameter int CFG_AW     = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [WORD_W-1:0]            cfg_wdata,
    output logic [HASH_WORDS*WORD_W-1:0] tbl_flat,
    output logic [DA_W-1:0]              station,
    output ctrl_t                        ctrl
);
    localparam int STA_WORDS = DA_W / WORD_W;
    localparam int STA_BASE  = HASH_WORDS;
    localparam int CTRL_OFF  = HASH_WORDS + STA_WORDS;

    logic [WORD_W-1:0] tbl_q [HASH_WORDS];
    logic [WORD_W-1:0] sta_q [STA_WORDS];
    ctrl_t             ctrl_q;

    for (genvar g = 0; g < HASH_WORDS; g++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (rst)
                tbl_q[g] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(g))
                tbl_q[g] <= cfg_wdata;
        end
        assign tbl_flat[g*WORD_W +: WORD_W] = tbl_q[g];
    end

    // word 0 carries the last bytes, so it sits lowest in the station vector
    for (genvar s = 0; s < STA_WORDS; s++) begin : g_sta
        always_ff @(posedge clk) begin
            if (rst)
                sta_q[s] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(STA_BASE + s))
                sta_q[s] <= cfg_wdata;
        end
        assign station[s*WORD_W +: WORD_W] = sta_q[s];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (cfg_we && cfg_addr == CFG_AW'(CTRL_OFF))
            ctrl_q <= ctrl_t'(cfg_wdata[1:0]);
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/addr_filt_crc.sv
module addr_filt_crc
    import addr_filt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            da_valid,
    input  logic [DA_W-1:0] da,
    output logic            start,
    output hash_req_t       req
);
    localparam int NBYTES = DA_W / 8;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    eng_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q;
    logic [DA_W-1:0]  da_q;
    logic [DA_W-1:0]  sh_q;

    assign start = da_valid && (state_q == ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
            crc_q   <= '1;
            da_q    <= '0;
            sh_q    <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        state_q <= ENG_SHIFT;
                        cnt_q   <= '0;
                        crc_q   <= '1;
                        da_q    <= da;
                        sh_q    <= da;
                    end
                end
                ENG_SHIFT: begin
                    crc_q <= crc_step_byte(crc_q, sh_q[DA_W-1 -: 8]);
                    sh_q  <= sh_q << 8;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(NBYTES - 1))
                        state_q <= ENG_FINAL;
                end
                ENG_FINAL: begin
                    state_q <= ENG_IDLE;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        req.valid = (state_q == ENG_FINAL);
        req.crc   = crc_q;
        req.da    = da_q;
    end

endmodule

// File: rtl/addr_filt_decide.sv
module addr_filt_decide
    import addr_filt_pkg::*;
#(
    parameter int HASH_WORDS = 16,
    parameter int WORD_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  hash_req_t                    req,
    input  logic [HASH_WORDS*WORD_W-1:0] tbl_flat,
    input  logic [DA_W-1:0]              station,
    input  ctrl_t                        ctrl,
    output logic                         dec_valid,
    output logic                         dec_accept
);
    localparam int WSEL_W = $clog2(HASH_WORDS);
    localparam int BSEL_W = $clog2(WORD_W);
    localparam int IDX_W  = WSEL_W + BSEL_W;

    logic [IDX_W-1:0]  idx;
    logic [WSEL_W-1:0] wsel;
    logic [BSEL_W-1:0] bsel;
    logic [WORD_W-1:0] word;
    logic              is_group, is_bcast, uc_hit, hash_hit, acc_c;

    always_comb begin
        idx      = req.crc[CRC_W-1 -: IDX_W];
        wsel     = idx[IDX_W-1 -: WSEL_W];
        bsel     = idx[BSEL_W-1:0];
        word     = tbl_flat[wsel*WORD_W +: WORD_W];
        is_group = req.da[DA_W-8];
        is_bcast = &req.da;
        uc_hit   = !is_group && (req.da == station);
        hash_hit = is_group && ctrl.hash_en && word[bsel];
        acc_c    = ctrl.promisc || is_bcast || uc_hit || hash_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= req.valid;
            dec_accept <= req.valid && acc_c;
        end
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import addr_filt_pkg::*;
#(
    parameter int HASH_WORDS = 16,
    parameter int WORD_W     = 16,
    localparam int CFG_AW    = $clog2(HASH_WORDS + DA_W / WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              da_valid,
    input  logic [DA_W-1:0]   da,
    output logic              dec_valid,
    output logic              dec_accept
);
    logic [HASH_WORDS*WORD_W-1:0] tbl_w;
    logic [DA_W-1:0]              station_w;
    ctrl_t                        ctrl_w;
    logic                         eng_start;
    hash_req_t                    hreq;

    addr_filt_regs #(
        .HASH_WORDS(HASH_WORDS),
        .WORD_W    (WORD_W),
        .CFG_AW    (CFG_AW)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .tbl_flat (tbl_w),
        .station  (station_w),
        .ctrl     (ctrl_w)
    );

    addr_filt_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .da_valid(da_valid),
        .da      (da),
        .start   (eng_start),
        .req     (hreq)
    );

    addr_filt_decide #(
        .HASH_WORDS(HASH_WORDS),
        .WORD_W    (WORD_W)
    ) u_decide (
        .clk       (clk),
        .rst       (rst),
        .req       (hreq),
        .tbl_flat  (tbl_w),
        .station   (station_w),
        .ctrl      (ctrl_w),
        .dec_valid (dec_valid),
        .dec_accept(dec_accept)
    );

endmodule

// File: rtl/addr_filt_chk.sv
module addr_filt_chk
    import addr_filt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [DA_W-1:0] da_hold,
    input logic [DA_W-1:0] station,
    input ctrl_t           ctrl,
    input logic            dec_valid,
    input logic            dec_accept
);
    logic [7:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= {pend_q[6:0], start};
    end

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        pend_q[7] |-> dec_valid);                                                     // R2
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> pend_q[7]);                                                     // R2
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |-> (pend_q[6:0] == 7'd0));                                             // R3
    AST_STATION_HIT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !da_hold[40] && da_hold == $past(station)) |-> dec_accept);    // R4
    AST_STATION_MISS: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !da_hold[40] && da_hold != $past(station) && !$past(ctrl.promisc))
        |-> !dec_accept);                                                             // R5
    AST_HASH_OFF_REJECT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && da_hold[40] && !(&da_hold) && !$past(ctrl.promisc) && !$past(ctrl.hash_en))
        |-> !dec_accept);                                                             // R7
    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(ctrl.promisc)) |-> dec_accept);                           // R8
    AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && (&da_hold)) |-> dec_accept);                                    // R9

endmodule

bind rx_addr_filter addr_filt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (eng_start),
    .da_hold   (hreq.da),
    .station   (station_w),
    .ctrl      (ctrl_w),
    .dec_valid (dec_valid),
    .dec_accept(dec_accept)
);

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        dec_valid, dec_accept;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [15:0] tbl_m [16];
    logic [47:0] sta_m = '0;
    logic        hen_m = 1'b0;
    logic        pro_m = 1'b0;

    always #5 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        logic fb;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 8; j++) begin
                fb = c[0] ^ a[40 - 8*i + j];
                c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = ref_crc(a);
        return c[31:24];
    endfunction

    function automatic logic exp_acc(input logic [47:0] a);
        logic [7:0] ix = ref_idx(a);
        logic grp = a[40];
        if (pro_m || (&a)) return 1'b1;
        if (!grp) return a == sta_m;
        return hen_m && tbl_m[ix[7:4]][ix[3:0]];
    endfunction

    task automatic check(input logic act, input logic expv, input string req, input string what);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, expv);
        end
    endtask

    task automatic wr(input int off, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(off); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (off < 16)       tbl_m[off] = d;
        else if (off == 16) sta_m[15:0]  = d;
        else if (off == 17) sta_m[31:16] = d;
        else if (off == 18) sta_m[47:32] = d;
        else if (off == 19) begin hen_m = d[0]; pro_m = d[1]; end
    endtask

    task automatic probe(input logic [47:0] a, input string req, input string what);
        logic e = exp_acc(a);
        @(negedge clk);
        da_valid = 1'b1; da = a;
        @(posedge clk);
        @(negedge clk);
        da_valid = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(dec_valid, 1'b0, "R2", "no decision before seventh edge");
        @(posedge clk);
        @(negedge clk);
        check(dec_valid, 1'b1, "R2", "decision at seventh edge");
        check(dec_accept, e, req, what);
        @(posedge clk);
        @(negedge clk);
        check(dec_valid, 1'b0, "R2", "decision is one cycle");
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(dec_valid, 1'b0, "R1", "valid low after reset");
        check(dec_accept, 1'b0, "R1", "accept low after reset");
        probe(48'h0, "R1", "zero station matches zero address");
        probe(48'h0100_0000_0000, "R1", "group rejected with hash off");
    endtask

    task automatic t_station;
        wr(16, 16'h4455); wr(17, 16'h2233); wr(18, 16'h0211);
        probe(48'h0211_2233_4455, "R4", "station address accepted");
        probe(48'h0211_2233_4454, "R5", "last byte differs");
        probe(48'h4455_2233_0211, "R5", "word order swapped");
        probe(48'h1102_3322_5544, "R5", "bytes swapped in words");
    endtask

    task automatic t_hash;
        logic [47:0] m1 = 48'h0100_5E00_0001;
        logic [7:0]  ix = ref_idx(m1);
        wr(19, 16'h0001);
        wr(int'(ix[7:4]), 16'(1) << ix[3:0]);
        probe(m1, "R6", "hash bit set accepts");
        check(exp_acc(m1), 1'b1, "R6", "model sanity");
        probe(48'h3333_0000_0001, "R6", "other group per table");
        probe(48'h0180_C200_0000, "R6", "third group per table");
        wr(int'(ix[7:4]), 16'(1) << (ix[3:0] ^ 4'h1));
        probe(m1, "R6", "neighbour bit does not accept");
        wr(int'(ix[7:4] ^ 4'h1), 16'(1) << ix[3:0]);
        probe(m1, "R6", "neighbour word does not accept");
        wr(int'(ix[7:4]), 16'(1) << ix[3:0]);
        wr(19, 16'h0000);
        probe(m1, "R7", "hash off rejects set bit");
    endtask

    task automatic t_all_ones;
        for (int k = 0; k < 16; k++) wr(k, 16'hFFFF);
        wr(19, 16'h0001);
        probe(48'h0100_5E7F_1234, "R10", "full table group a");
        probe(48'hFF00_0000_0001, "R10", "full table group b");
        probe(48'h3333_FF00_00AB, "R10", "full table group c");
        wr(19, 16'h0000);
        probe(48'h3333_FF00_00AB, "R7", "full table but hash off");
    endtask

    task automatic t_promisc_bcast;
        probe(48'hFFFF_FFFF_FFFF, "R9", "broadcast with all off");
        wr(19, 16'h0002);
        probe(48'h0A0B_0C0D_0E0F, "R8", "promisc unicast miss");
        probe(48'h0100_5E00_0099, "R8", "promisc group with hash off");
        wr(19, 16'h0000);
        probe(48'h0A0B_0C0D_0E0F, "R5", "promisc off rejects again");
    endtask

    task automatic t_busy;
        int pulses = 0;
        @(negedge clk);
        da_valid = 1'b1; da = 48'h0211_2233_4455;
        @(posedge clk);
        @(negedge clk);
        da = 48'h0A0B_0C0D_0E0F;
        repeat (7) @(posedge clk);
        @(negedge clk);
        check(dec_valid, 1'b1, "R3", "first address decided on time");
        check(dec_accept, 1'b1, "R3", "result belongs to first address");
        da_valid = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (dec_valid) pulses++;
        end
        check(pulses == 0, 1'b1, "R3", "no decision from busy strobes");
    endtask

    initial begin
        for (int k = 0; k < 16; k++) tbl_m[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_station();
        t_hash();
        t_all_ones();
        for (int k = 0; k < 16; k++) wr(k, 16'h0000);
        t_promisc_bcast();
        t_busy();
        probe(48'h0211_2233_4455, "R4", "back-to-back after busy test");
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule